// File: doc/BRIEF.md
# Real-Time Clock Time and Alarm Register Block

This block is the software-facing core of a real-time clock. It keeps a 32-bit seconds count that moves forward on each one-second strobe from an external tick generator. It compares that count with a 32-bit alarm value and raises two interrupts: one for each second and one for the alarm. Software reaches it through a plain 32-bit register bus. The bus uses word addresses, has a single-cycle write strobe and returns read data combinationally.

Loading a new time is deferred. A write to the time-load register parks the value and marks it pending. The count takes that value at the next one-second strobe, in place of the usual increment. The parked value can be read back at any time. Software clears the seconds status bit just after loading. While that bit is still clear, the pending value is the time to report. Once the bit is set again, the live count is the time to report.

The block also stores a calibration word for the tick generator and two control enables. It exposes the live sub-second tick count that the generator supplies.

Top module: `rtc_timekeeper`

Word addresses (byte offset / 4): 0 time load (write), 1 time load read-back, 2 calibration write, 3 calibration read-back, 4 current time, 5 sub-second tick, 6 alarm, 8 interrupt status, 9 interrupt mask, 10 interrupt enable, 11 interrupt disable, 16 control.

## Requirements
- R1: After reset, current time, alarm, interrupt status, interrupt mask and control all read 0, and both interrupt outputs are low.
- R2: A write to address 0 is readable at once at address 1. The current time (address 4) does not change in any cycle without a one-second strobe.
- R3: On a one-second strobe with a load pending, the current time takes the last value written to address 0, and the pending state clears. If a load is written in the same cycle as a strobe, that load stays pending for the next strobe.
- R4: On a one-second strobe with no load pending, the current time increments by one and wraps from 0xFFFFFFFF to 0.
- R5: Status bit 0 sets on every one-second strobe, whatever the mask.
- R6: Status bit 1 sets on a strobe after which the current time equals the alarm register (address 6). Writing an alarm equal to the present time sets nothing.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set event and a clear hit the same bit in the same cycle, the set wins.
- R8: Writing 1 to bit n of address 10 sets mask bit n, and writing 1 to bit n of address 11 clears it. The mask reads at address 9.
- R9: The seconds interrupt output equals status bit 0 AND mask bit 0. The alarm interrupt output equals status bit 1 AND mask bit 1.
- R10: The control register (address 16) stores bits 31 (battery switchover enable) and 24 (oscillator enable) only. All other bits read 0.
- R11: A write to address 2 stores its low 21 bits as calibration, readable at address 3 with the upper bits 0.
- R12: Address 5 returns the 16-bit tick count input, zero-extended.
- R13: Write-only addresses (0, 2, 10, 11) and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle strobe at each second boundary |
| tick_cnt_i | input | 16 | Live sub-second count from the tick generator |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_sec_o | output | 1 | Seconds interrupt |
| irq_alarm_o | output | 1 | Alarm interrupt |

## Verification
The hardest situations to reach from the ports are the coincidences. A load and a strobe can land in the same cycle. A status clear can meet a set event on the same bit. The alarm can be hit through a load or through the 32-bit wrap rather than by counting. Directed steps create each of these: a load of 0xFFFFFFFF followed by a strobe wraps the count onto an alarm of 0, and a strobe is driven together with a status clear. The random phase often writes the alarm or the load value close to the present time, so that hits and load/strobe collisions recur under mixed traffic.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned IRQ_N = 2;

  localparam int unsigned SRC_SEC = 0;
  localparam int unsigned SRC_ALARM = 1;

  localparam int unsigned CTRL_BATT_BIT = 31;
  localparam int unsigned CTRL_OSC_BIT = 24;

  localparam logic [ADDR_W-1:0] A_LOAD_WR  = 5'd0;
  localparam logic [ADDR_W-1:0] A_LOAD_RD  = 5'd1;
  localparam logic [ADDR_W-1:0] A_CAL_WR   = 5'd2;
  localparam logic [ADDR_W-1:0] A_CAL_RD   = 5'd3;
  localparam logic [ADDR_W-1:0] A_NOW      = 5'd4;
  localparam logic [ADDR_W-1:0] A_SUBSEC   = 5'd5;
  localparam logic [ADDR_W-1:0] A_ALARM    = 5'd6;
  localparam logic [ADDR_W-1:0] A_STS      = 5'd8;
  localparam logic [ADDR_W-1:0] A_MASK     = 5'd9;
  localparam logic [ADDR_W-1:0] A_IEN      = 5'd10;
  localparam logic [ADDR_W-1:0] A_IDIS     = 5'd11;
  localparam logic [ADDR_W-1:0] A_CTRL     = 5'd16;
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic              load_wr_i,
  input  logic              alarm_wr_i,
  input  logic [TIME_W-1:0] wval_i,
  output logic [TIME_W-1:0] now_o,
  output logic [TIME_W-1:0] load_rb_o,
  output logic [TIME_W-1:0] alarm_o,
  output logic              alarm_ev_o
);
  logic [TIME_W-1:0] now_q, load_q, alarm_q, now_nxt;
  logic              pend_q;

  // pending load replaces the increment on the strobe
  assign now_nxt = pend_q ? load_q : now_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q   <= '0;
      load_q  <= '0;
      alarm_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (sec_tick_i) now_q <= now_nxt;
      if (load_wr_i) begin
        load_q <= wval_i;
        pend_q <= 1'b1;
      end else if (sec_tick_i) begin
        pend_q <= 1'b0;
      end
      if (alarm_wr_i) alarm_q <= wval_i;
    end
  end

  assign alarm_ev_o = sec_tick_i && (now_nxt == alarm_q);
  assign now_o      = now_q;
  assign load_rb_o  = load_q;
  assign alarm_o    = alarm_q;

  AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_tick_i |=> $stable(now_q)); // R2
  AST_TIME_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && pend_q) |=> (now_q == $past(load_q))); // R3
  AST_LOAD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && !load_wr_i) |=> !pend_q); // R3
  AST_TIME_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && !pend_q) |=> (now_q == $past(now_q) + 1'b1)); // R4
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic         clr_wr_i,
  input  logic         en_wr_i,
  input  logic         dis_wr_i,
  input  logic [N-1:0] wbits_i,
  output logic [N-1:0] sts_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] sts_q, mask_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_q[i]  <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        // event has priority over write-one-to-clear
        if (ev_i[i])                       sts_q[i] <= 1'b1;
        else if (clr_wr_i && wbits_i[i])   sts_q[i] <= 1'b0;
        if (en_wr_i && wbits_i[i])         mask_q[i] <= 1'b1;
        else if (dis_wr_i && wbits_i[i])   mask_q[i] <= 1'b0;
      end
    end

    assign irq_o[i] = sts_q[i] & mask_q[i];

    AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[i] |=> sts_q[i]); // R5
    AST_STS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_wr_i && wbits_i[i] && !ev_i[i]) |=> !sts_q[i]); // R7
    AST_MASK_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_wr_i && wbits_i[i]) |=> mask_q[i]); // R8
    AST_MASK_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dis_wr_i && wbits_i[i]) |=> !mask_q[i]); // R8
  end

  assign sts_o  = sts_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs #(
  parameter int unsigned CAL_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cal_wr_i,
  input  logic [CAL_W-1:0] cal_val_i,
  input  logic             ctrl_wr_i,
  input  logic             batt_i,
  input  logic             osc_i,
  output logic [CAL_W-1:0] cal_o,
  output logic             batt_o,
  output logic             osc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_o  <= '0;
      batt_o <= 1'b0;
      osc_o  <= 1'b0;
    end else begin
      if (cal_wr_i) cal_o <= cal_val_i;
      if (ctrl_wr_i) begin
        batt_o <= batt_i;
        osc_o  <= osc_i;
      end
    end
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned TICK_W = 16,
  parameter int unsigned CAL_W  = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic [TICK_W-1:0] tick_cnt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_sec_o,
  output logic              irq_alarm_o
);
  logic [TIME_W-1:0] now_w, load_rb_w, alarm_w;
  logic              alarm_ev_w;
  logic [IRQ_N-1:0]  ev_w, sts_w, mask_w, irq_w;
  logic [CAL_W-1:0]  cal_w;
  logic              batt_w, osc_w;
  logic [BUS_W-1:0]  ctrl_rd;

  logic wr_load, wr_alarm, wr_sts, wr_ien, wr_idis, wr_cal, wr_ctrl;
  assign wr_load  = wr_en_i && (addr_i == A_LOAD_WR);
  assign wr_alarm = wr_en_i && (addr_i == A_ALARM);
  assign wr_sts   = wr_en_i && (addr_i == A_STS);
  assign wr_ien   = wr_en_i && (addr_i == A_IEN);
  assign wr_idis  = wr_en_i && (addr_i == A_IDIS);
  assign wr_cal   = wr_en_i && (addr_i == A_CAL_WR);
  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);

  rtc_time_core #(.TIME_W(TIME_W)) u_time (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_tick_i (sec_tick_i),
    .load_wr_i  (wr_load),
    .alarm_wr_i (wr_alarm),
    .wval_i     (wdata_i[TIME_W-1:0]),
    .now_o      (now_w),
    .load_rb_o  (load_rb_w),
    .alarm_o    (alarm_w),
    .alarm_ev_o (alarm_ev_w)
  );

  always_comb begin
    ev_w            = '0;
    ev_w[SRC_SEC]   = sec_tick_i;
    ev_w[SRC_ALARM] = alarm_ev_w;
  end

  rtc_irq_unit #(.N(IRQ_N)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_w),
    .clr_wr_i (wr_sts),
    .en_wr_i  (wr_ien),
    .dis_wr_i (wr_idis),
    .wbits_i  (wdata_i[IRQ_N-1:0]),
    .sts_o    (sts_w),
    .mask_o   (mask_w),
    .irq_o    (irq_w)
  );

  rtc_cfg_regs #(.CAL_W(CAL_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cal_wr_i  (wr_cal),
    .cal_val_i (wdata_i[CAL_W-1:0]),
    .ctrl_wr_i (wr_ctrl),
    .batt_i    (wdata_i[CTRL_BATT_BIT]),
    .osc_i     (wdata_i[CTRL_OSC_BIT]),
    .cal_o     (cal_w),
    .batt_o    (batt_w),
    .osc_o     (osc_w)
  );

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[CTRL_BATT_BIT] = batt_w;
    ctrl_rd[CTRL_OSC_BIT]  = osc_w;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_LOAD_RD: rdata_o = BUS_W'(load_rb_w);
      A_CAL_RD:  rdata_o = BUS_W'(cal_w);
      A_NOW:     rdata_o = BUS_W'(now_w);
      A_SUBSEC:  rdata_o = BUS_W'(tick_cnt_i);
      A_ALARM:   rdata_o = BUS_W'(alarm_w);
      A_STS:     rdata_o = BUS_W'(sts_w);
      A_MASK:    rdata_o = BUS_W'(mask_w);
      A_CTRL:    rdata_o = ctrl_rd;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_sec_o   = irq_w[SRC_SEC];
  assign irq_alarm_o = irq_w[SRC_ALARM];

  AST_ALARM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_w[SRC_ALARM]) |-> (now_w == $past(alarm_w))); // R6
  AST_CTRL_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL) |-> (rdata_o[CTRL_OSC_BIT-1:0] == '0)); // R10
  AST_WO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_LOAD_WR || addr_i == A_IEN || addr_i == A_IDIS) |-> (rdata_o == '0)); // R13
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_w[SRC_ALARM] |-> !irq_alarm_o); // R9
endmodule

// File: tb/rtc_timekeeper_test.sv
module rtc_timekeeper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic [15:0] tick_cnt = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_sec, irq_alarm;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_time = 0, m_load = 0, m_alarm = 0, m_ctrl = 0;
  logic [20:0] m_cal = 0;
  logic [1:0]  m_sts = 0, m_mask = 0;
  bit          m_pend = 0;

  always #5 clk = ~clk;

  rtc_timekeeper uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sec_tick_i (sec_tick),
    .tick_cnt_i (tick_cnt),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_sec_o  (irq_sec),
    .irq_alarm_o(irq_alarm)
  );

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a)
      5'd1:  return m_load;
      5'd3:  return 32'(m_cal);
      5'd4:  return m_time;
      5'd5:  return 32'(tick_cnt);
      5'd6:  return m_alarm;
      5'd8:  return 32'(m_sts);
      5'd9:  return 32'(m_mask);
      5'd16: return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'd1:  return "R2";
      5'd3:  return "R11";
      5'd4:  return "R4";
      5'd5:  return "R12";
      5'd6:  return "R6";
      5'd8:  return "R7";
      5'd9:  return "R8";
      5'd16: return "R10";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic tk, input logic wr, input logic [4:0] a, input logic [31:0] d);
    logic [31:0] nt;
    logic [1:0]  ev;
    @(negedge clk);
    sec_tick = tk; wr_en = wr; addr = a; wdata = d;
    @(posedge clk);
    #1;
    sec_tick = 1'b0; wr_en = 1'b0;
    ev = 2'b00;
    nt = m_time;
    if (tk) begin
      nt = m_pend ? m_load : m_time + 1;
      ev[0] = 1'b1;
      if (nt == m_alarm) ev[1] = 1'b1;
      m_pend = 0;
    end
    m_time = nt;
    if (wr) begin
      case (a)
        5'd0:  begin m_load = d; m_pend = 1; end
        5'd2:  m_cal = d[20:0];
        5'd6:  m_alarm = d;
        5'd8:  m_sts = m_sts & ~d[1:0];
        5'd10: m_mask = m_mask | d[1:0];
        5'd11: m_mask = m_mask & ~d[1:0];
        5'd16: m_ctrl = d & 32'h8100_0000;
        default: ;
      endcase
    end
    m_sts = m_sts | ev;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0; addr = a;
    #1;
    v = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic irq_chk();
    chk("R9 sec irq", 32'(irq_sec), 32'(m_sts[0] & m_mask[0]));
    chk("R9 alarm irq", 32'(irq_alarm), 32'(m_sts[1] & m_mask[1]));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] alist [14];
    void'($urandom(32'h5EC0_0DD5));
    alist = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd8, 5'd9, 5'd10, 5'd11, 5'd16, 5'd7, 5'd20};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 time", 5'd4, 0);
    rd_chk("R1 alarm", 5'd6, 0);
    rd_chk("R1 status", 5'd8, 0);
    rd_chk("R1 mask", 5'd9, 0);
    rd_chk("R1 ctrl", 5'd16, 0);
    chk("R1 irqs", 32'({irq_sec, irq_alarm}), 0);

    // R2 deferred load
    step(0, 1, 5'd0, 32'h0000_1000);
    rd_chk("R2 readback", 5'd1, 32'h0000_1000);
    rd_chk("R2 time unchanged", 5'd4, 0);
    step(0, 0, 5'd0, 0);
    rd_chk("R2 no strobe", 5'd4, 0);
    // R3 load on strobe, R4 then increment
    step(1, 0, 5'd0, 0);
    rd_chk("R3 loaded", 5'd4, 32'h0000_1000);
    step(1, 0, 5'd0, 0);
    rd_chk("R4 increment", 5'd4, 32'h0000_1001);
    // R5 status sets while masked
    rd_chk("R5 sec status", 5'd8, 32'h1);
    chk("R9 masked sec irq", 32'(irq_sec), 0);
    // R7 clear, then set beats clear
    step(0, 1, 5'd8, 32'h1);
    rd_chk("R7 cleared", 5'd8, 0);
    step(1, 1, 5'd8, 32'h1);
    rd_chk("R7 set wins", 5'd8, 32'h1);
    // R3 load colliding with strobe stays pending
    step(1, 1, 5'd0, 32'h0000_2000);
    rd_chk("R3 collide not loaded", 5'd4, 32'h0000_1003);
    step(1, 0, 5'd0, 0);
    rd_chk("R3 collide loaded next", 5'd4, 32'h0000_2000);
    // R8 mask
    step(0, 1, 5'd10, 32'h3);
    rd_chk("R8 enable", 5'd9, 32'h3);
    chk("R9 sec irq on", 32'(irq_sec), 1);
    step(0, 1, 5'd11, 32'h1);
    rd_chk("R8 disable", 5'd9, 32'h2);
    // R4 wrap onto alarm 0, R6
    step(0, 1, 5'd0, 32'hFFFF_FFFF);
    step(1, 0, 5'd0, 0);
    step(0, 1, 5'd8, 32'h3);
    rd_chk("R6 no hit yet", 5'd8, 0);
    step(1, 0, 5'd0, 0);
    rd_chk("R4 wrap", 5'd4, 0);
    rd_chk("R6 alarm hit", 5'd8, 32'h3);
    chk("R9 alarm irq", 32'(irq_alarm), 1);
    // R6 alarm written equal to present time does not fire
    step(0, 1, 5'd8, 32'h3);
    step(0, 1, 5'd6, 32'h0);
    rd_chk("R6 no hit on write", 5'd8, 0);
    // R10, R11, R12, R13
    step(0, 1, 5'd16, 32'hFFFF_FFFF);
    rd_chk("R10 ctrl bits", 5'd16, 32'h8100_0000);
    step(0, 1, 5'd2, 32'hFFFF_FFFF);
    rd_chk("R11 calibration", 5'd3, 32'h001F_FFFF);
    rd_chk("R13 cal write addr", 5'd2, 0);
    tick_cnt = 16'hBEEF;
    rd_chk("R12 tick count", 5'd5, 32'h0000_BEEF);
    rd_chk("R13 load write addr", 5'd0, 0);
    rd_chk("R13 unmapped", 5'd7, 0);

    // constrained random
    for (int i = 0; i < 2500; i++) begin
      logic [4:0]  a;
      logic [31:0] d;
      logic        tk, wr;
      a  = alist[$urandom % 14];
      tk = ($urandom % 4) == 0;
      wr = ($urandom % 2) == 0;
      case ($urandom % 4)
        0: d = m_time + ($urandom % 3);
        1: d = m_alarm - ($urandom % 2);
        2: d = {30'h0, 2'($urandom)};
        default: d = $urandom;
      endcase
      if (a == 5'd8 && ($urandom % 2) == 0) d = 32'h3;
      tick_cnt = 16'($urandom);
      step(tk, wr, a, d);
      a = alist[$urandom % 14];
      rd_chk(tag_of(a), a, exp_rd(a));
      irq_chk();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule